// File: doc/BRIEF.md
# Phase-Correct PWM Timer

This block is an 8-bit timer that produces a symmetric, center-aligned pulse-width-modulated waveform. A counter sweeps from zero to its maximum and back down to zero, one step per timer tick. Each timer tick is an enable pulse taken from a free-running prescaler, chosen by a 3-bit clock-select field. Software can load the counter and the compare value. On every tick the counter is compared with the compare value. When the two are equal, the block raises a one-cycle match pulse and, depending on a 2-bit output mode, sets or clears the waveform pin according to the direction of the count.

A load of the counter from software suppresses the compare match on the tick that follows. This prevents a spurious edge when the count is moved by hand. When the compare value is at either end of the sweep, the pin holds one level for the whole period. In the two output-off modes, the pin is released: its enable is low and it is driven to zero.

Top module: `pwm_phase_timer`

## Requirements
- R1: After a synchronous reset, `count_o`, `compare_o`, `wave_o`, `wave_oe_o` and `match_o` are all zero, and the count direction is upward.
- R2: On each tick the count moves one step: 0,1,…,255,254,…,1,0,1,… It reverses at 255 and at 0 without repeating an end value. With clock select 000 the count holds.
- R3: Clock-select encoding on `ctrl_clksel`: 000 stopped, 001 divide by 1, 010 by 8, 011 by 32, 100 by 64, 101 by 128, 110 by 256, 111 by 1024. The prescaler is cleared while the select is 000, so after moving from 000 to a divisor N, the first count change appears N cycles after the control write edge.
- R4: When a tick sees the count equal to the compare value, `match_o` is high for exactly the next cycle. The count advances on that same edge.
- R5: In output mode 10 (`ctrl_wmode`), a match while counting up drives the pin low, and a match while counting down drives it high.
- R6: In output mode 11, a match while counting up drives the pin high, and a match while counting down drives it low.
- R7: In output modes 00 and 01, `wave_oe_o` is 0 and `wave_o` is 0. The internal waveform level is held unchanged.
- R8: A write to the counter (`cnt_we`) takes effect on the next edge. It suppresses the match on the first tick after the write. A tick in the same cycle as the write also produces no match.
- R9: With compare value 255, mode 10 keeps the pin constantly high and mode 11 keeps it constantly low for whole periods.
- R10: With compare value 0, mode 10 keeps the pin constantly low and mode 11 keeps it constantly high for whole periods.
- R11: A write to the compare register (`cmp_we`) is visible on `compare_o` from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_we | input | 1 | Load the counter |
| cnt_wdata | input | 8 | Counter load value |
| cmp_we | input | 1 | Load the compare register |
| cmp_wdata | input | 8 | Compare load value |
| ctrl_we | input | 1 | Load clock select and output mode |
| ctrl_clksel | input | 3 | Clock-select value |
| ctrl_wmode | input | 2 | Output mode value |
| count_o | output | 8 | Current count |
| compare_o | output | 8 | Current compare value |
| wave_o | output | 1 | Waveform pin |
| wave_oe_o | output | 1 | Waveform pin enable |
| match_o | output | 1 | One-cycle compare-match pulse |

## Verification
The inline properties check the following on every cycle:
- the count moves by exactly one per tick and holds between ticks;
- the count reverses at the top;
- prescaled ticks are single-cycle pulses;
- a blocked tick never produces a match;
- the waveform level freezes while the pin is released;
- the direction-dependent clear or set in each mode.

The exact divisor of each clock select, and the constant pin levels at compare values 0 and 255, need whole periods of stimulus. The same holds for the suppression that follows a counter load. These are shown only by the bench scenarios, which compare every cycle against a reference model.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

    localparam int PRE_W = 10;
    localparam int SEL_W = 3;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    typedef enum logic [1:0] {
        WM_OFF    = 2'b00,
        WM_RSVD   = 2'b01,
        WM_CLR_UP = 2'b10,
        WM_SET_UP = 2'b11
    } wmode_e;

    typedef struct packed {
        logic [SEL_W-1:0] clksel;
        wmode_e           wmode;
    } ctrl_t;

    // log2 of the division ratio for each clock-select code
    function automatic int unsigned tap_width(input logic [SEL_W-1:0] sel);
        case (sel)
            3'd2:    return 3;
            3'd3:    return 5;
            3'd4:    return 6;
            3'd5:    return 7;
            3'd6:    return 8;
            3'd7:    return 10;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
    import pwm_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W:0]   mask_w;
    logic [PRE_W-1:0] mask;

    always_ff @(posedge clk) begin
        if (rst || sel == '0) pre_q <= '0;
        else                  pre_q <= pre_q + PRE_W'(1);
    end

    always_comb begin
        mask_w = ((PRE_W+1)'(1) << tap_width(sel)) - (PRE_W+1)'(1);
        mask   = mask_w[PRE_W-1:0];
        tick   = (sel != '0) && ((pre_q & mask) == mask);
    end

    // R3: divided ticks are single-cycle pulses
    p_single_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        (sel > 3'd1 && tick) |=> (!tick || sel != $past(sel)));

endmodule

// File: rtl/pwm_updown_counter.sv
module pwm_updown_counter
    import pwm_timer_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt_q,
    output dir_e         dir_q
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [W-1:0] nxt;
    dir_e         dir_n;

    always_comb begin
        nxt   = cnt_q;
        dir_n = dir_q;
        if (dir_q == DIR_UP) begin
            if (cnt_q == TOP) begin
                nxt   = TOP - W'(1);
                dir_n = DIR_DOWN;
            end else begin
                nxt = cnt_q + W'(1);
                if (nxt == TOP) dir_n = DIR_DOWN;
            end
        end else begin
            if (cnt_q == '0) begin
                nxt   = W'(1);
                dir_n = DIR_UP;
            end else begin
                nxt = cnt_q - W'(1);
                if (nxt == '0) dir_n = DIR_UP;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            dir_q <= DIR_UP;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick) begin
            cnt_q <= nxt;
            dir_q <= dir_n;
        end
    end

    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && !load) |=> (cnt_q == $past(cnt_q) + W'(1) || cnt_q == $past(cnt_q) - W'(1)));

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> $stable(cnt_q));

    p_top_turn_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && !load && cnt_q == TOP) |=> (dir_q == DIR_DOWN && cnt_q == TOP - W'(1)));

endmodule

// File: rtl/pwm_compare_out.sv
module pwm_compare_out
    import pwm_timer_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cmp,
    input  dir_e         dir,
    input  wmode_e       wmode,
    output logic         match_q,
    output logic         wave_q
);
    logic blk_q;
    logic hit;

    assign hit = tick && !blk_q && !load && (cnt == cmp);

    always_ff @(posedge clk) begin
        if (rst) begin
            blk_q   <= 1'b0;
            match_q <= 1'b0;
            wave_q  <= 1'b0;
        end else begin
            if (load)      blk_q <= 1'b1;
            else if (tick) blk_q <= 1'b0;
            match_q <= hit;
            if (hit && wmode[1])
                wave_q <= (dir == DIR_UP) ? (wmode == WM_SET_UP) : (wmode == WM_CLR_UP);
        end
    end

    p_blocked_r8: assert property (@(posedge clk) disable iff (rst)
        (blk_q && tick) |=> !match_q);

    p_detached_r7: assert property (@(posedge clk) disable iff (rst)
        (!wmode[1]) |=> $stable(wave_q));

    p_clear_up_r5: assert property (@(posedge clk) disable iff (rst)
        (hit && wmode == WM_CLR_UP && dir == DIR_UP) |=> !wave_q);

    p_set_up_r6: assert property (@(posedge clk) disable iff (rst)
        (hit && wmode == WM_SET_UP && dir == DIR_UP) |=> wave_q);

    p_match_tick_r4: assert property (@(posedge clk) disable iff (rst)
        match_q |-> $past(tick));

endmodule

// File: rtl/pwm_phase_timer.sv
module pwm_phase_timer
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             cmp_we,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             ctrl_we,
    input  logic [SEL_W-1:0] ctrl_clksel,
    input  logic [1:0]       ctrl_wmode,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] compare_o,
    output logic             wave_o,
    output logic             wave_oe_o,
    output logic             match_o
);
    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] cmp_q;
    logic             tick;
    dir_e             dir;
    logic             wave_lvl;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '{clksel: '0, wmode: WM_OFF};
            cmp_q  <= '0;
        end else begin
            if (ctrl_we) ctrl_q <= '{clksel: ctrl_clksel, wmode: wmode_e'(ctrl_wmode)};
            if (cmp_we)  cmp_q  <= cmp_wdata;
        end
    end

    pwm_prescaler u_pre (
        .clk  (clk),
        .rst  (rst),
        .sel  (ctrl_q.clksel),
        .tick (tick)
    );

    pwm_updown_counter #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .load     (cnt_we),
        .load_val (cnt_wdata),
        .cnt_q    (count_o),
        .dir_q    (dir)
    );

    pwm_compare_out #(.W(CNT_W)) u_cmp (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .load    (cnt_we),
        .cnt     (count_o),
        .cmp     (cmp_q),
        .dir     (dir),
        .wmode   (ctrl_q.wmode),
        .match_q (match_o),
        .wave_q  (wave_lvl)
    );

    assign compare_o = cmp_q;
    assign wave_oe_o = ctrl_q.wmode[1];
    assign wave_o    = wave_oe_o ? wave_lvl : 1'b0;

endmodule

// File: tb/pwm_phase_timer_tb_top.sv
module pwm_phase_timer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cnt_we = 1'b0, cmp_we = 1'b0, ctrl_we = 1'b0;
    logic [7:0] cnt_wdata = '0, cmp_wdata = '0;
    logic [2:0] ctrl_clksel = '0;
    logic [1:0] ctrl_wmode = '0;
    logic [7:0] count_o, compare_o;
    logic       wave_o, wave_oe_o, match_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_phase_timer dut_i (
        .clk(clk), .rst(rst),
        .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
        .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
        .ctrl_we(ctrl_we), .ctrl_clksel(ctrl_clksel), .ctrl_wmode(ctrl_wmode),
        .count_o(count_o), .compare_o(compare_o),
        .wave_o(wave_o), .wave_oe_o(wave_oe_o), .match_o(match_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // ---------------- reference model and scoreboard ----------------
    typedef struct {
        int cnt; int cmp; bit wave; bit oe; bit match; int mode;
    } exp_t;
    exp_t sb_q[$];

    int m_pre = 0, m_cnt = 0, m_cmp = 0, m_sel = 0, m_mode = 0;
    bit m_dir = 0, m_blk = 0, m_wave = 0, m_match = 0;

    function automatic int div_of(input int s);
        case (s)
            1: return 1;    2: return 8;    3: return 32;  4: return 64;
            5: return 128;  6: return 256;  7: return 1024;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        exp_t e;
        bit   t, h;
        cyc++;
        if (rst) begin
            m_pre = 0; m_cnt = 0; m_cmp = 0; m_sel = 0; m_mode = 0;
            m_dir = 0; m_blk = 0; m_wave = 0; m_match = 0;
        end else begin
            t = (m_sel != 0) && ((m_pre % div_of(m_sel)) == div_of(m_sel) - 1);
            h = t && !m_blk && !cnt_we && (m_cnt == m_cmp);
            m_match = h;
            if (h && m_mode >= 2)
                m_wave = (m_dir == 0) ? (m_mode == 3) : (m_mode == 2);
            if (cnt_we)  m_blk = 1;
            else if (t)  m_blk = 0;
            if (cnt_we) m_cnt = cnt_wdata;
            else if (t) begin
                if (m_dir == 0) begin
                    if (m_cnt == 255) begin m_cnt = 254; m_dir = 1; end
                    else begin m_cnt++; if (m_cnt == 255) m_dir = 1; end
                end else begin
                    if (m_cnt == 0) begin m_cnt = 1; m_dir = 0; end
                    else begin m_cnt--; if (m_cnt == 0) m_dir = 0; end
                end
            end
            m_pre = (m_sel == 0) ? 0 : (m_pre + 1) % 1024;
            if (ctrl_we) begin m_sel = ctrl_clksel; m_mode = ctrl_wmode; end
            if (cmp_we)  m_cmp = cmp_wdata;
        end
        e.cnt = m_cnt; e.cmp = m_cmp; e.oe = (m_mode >= 2);
        e.wave = e.oe ? m_wave : 1'b0; e.match = m_match; e.mode = m_mode;
        sb_q.push_back(e);
    end

    always @(negedge clk) begin
        exp_t e;
        if (sb_q.size() > 0 && !done) begin
            e = sb_q.pop_front();
            chk(count_o == e.cnt[7:0], "R2 count", count_o, e.cnt);
            chk(compare_o == e.cmp[7:0], "R11 compare", compare_o, e.cmp);
            chk(match_o == e.match, "R4 match", match_o, e.match);
            chk(wave_oe_o == e.oe, "R7 enable", wave_oe_o, e.oe);
            if (e.mode == 2)      chk(wave_o == e.wave, "R5 wave", wave_o, e.wave);
            else if (e.mode == 3) chk(wave_o == e.wave, "R6 wave", wave_o, e.wave);
            else                  chk(wave_o == e.wave, "R7 wave", wave_o, e.wave);
        end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        if (cyc > WDOG_LIMIT && !done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WDOG_LIMIT);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // ---------------- driver ----------------
    task automatic wr_ctrl(input int sel, input int mode);
        @(negedge clk);
        ctrl_we = 1; ctrl_clksel = 3'(sel); ctrl_wmode = 2'(mode);
        @(negedge clk);
        ctrl_we = 0;
    endtask

    task automatic wr_cmp(input int v);
        @(negedge clk);
        cmp_we = 1; cmp_wdata = 8'(v);
        @(negedge clk);
        cmp_we = 0;
    endtask

    task automatic wr_cnt(input int v);
        @(negedge clk);
        cnt_we = 1; cnt_wdata = 8'(v);
        @(negedge clk);
        cnt_we = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_count(input int v);
        for (int i = 0; i < 2000 && count_o != 8'(v); i++) @(negedge clk);
    endtask

    // whole-period level check
    task automatic level_check(input string req, input bit lvl);
        int bad = 0;
        idle(520);
        for (int i = 0; i < 510; i++) begin
            @(negedge clk);
            if (wave_o != lvl) bad++;
        end
        chk(bad == 0, req, bad, 0);
    endtask

    initial begin
        int n, start, mcount;
        idle(3);
        // R1: reset state
        chk(count_o == 0, "R1 count", count_o, 0);
        chk(compare_o == 0, "R1 compare", compare_o, 0);
        chk(wave_o == 0 && wave_oe_o == 0, "R1 pin", wave_o, 0);
        chk(match_o == 0, "R1 match", match_o, 0);
        @(negedge clk);
        rst = 0;

        // R2: stopped counter holds
        idle(50);
        chk(count_o == 0, "R2 stopped", count_o, 0);

        // R11: compare readback
        wr_cmp(100);
        chk(compare_o == 100, "R11 readback", compare_o, 100);

        // R5: full sweeps in mode 10
        wr_ctrl(1, 2);
        wait_count(255);
        @(negedge clk);
        chk(count_o == 254, "R2 top turn", count_o, 254);
        wait_count(0);
        @(negedge clk);
        chk(count_o == 1, "R2 bottom turn", count_o, 1);
        idle(600);

        // R6: mode 11 with another compare value
        wr_cmp(37);
        wr_ctrl(1, 3);
        idle(1100);

        // R9 / R10: end-of-range compare values
        wr_cmp(255); wr_ctrl(1, 2); level_check("R9 mode10", 1'b1);
        wr_ctrl(1, 3);              level_check("R9 mode11", 1'b0);
        wr_cmp(0);   wr_ctrl(1, 2); level_check("R10 mode10", 1'b0);
        wr_ctrl(1, 3);              level_check("R10 mode11", 1'b1);

        // R7: pin released in modes 00 and 01
        wr_cmp(60);
        wr_ctrl(1, 0);
        chk(wave_oe_o == 0 && wave_o == 0, "R7 mode00", wave_o, 0);
        idle(600);
        wr_ctrl(1, 1);
        chk(wave_oe_o == 0 && wave_o == 0, "R7 mode01", wave_o, 0);
        idle(600);

        // R8: counter load blocks the next match
        wr_cmp(50);
        wr_ctrl(1, 2);
        wait_count(40);
        wr_cnt(50);
        mcount = 0;
        for (int i = 0; i < 6; i++) begin
            if (match_o) mcount++;
            @(negedge clk);
        end
        chk(mcount == 0, "R8 blocked", mcount, 0);
        idle(600);

        // R3: each divisor
        for (int s = 2; s <= 7; s++) begin
            wr_ctrl(0, 2);
            idle(3);
            wr_ctrl(s, 2);
            start = count_o;
            n = 0;
            do begin
                @(negedge clk);
                n++;
            end while (count_o == 8'(start) && n < 3000);
            chk(n == div_of(s), "R3 divisor", n, div_of(s));
            idle(2 * div_of(s) + 5);
        end

        wr_ctrl(0, 0);
        idle(5);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule